// File: doc/BRIEF.md
# Buffered Power-of-Two PWM Timer

An 8-bit up-counting timer that drives a single PWM output flip-flop. Software picks the PWM period, which can be 64, 128 or 256 count ticks. It also picks a compare value that sets the duty point. The flip-flop inverts once when the count reaches the compare value and once more when the count wraps at the end of the period. Each period therefore has exactly two output transitions, and the duty point sits at the compare value. On every wrap the block raises an interrupt pulse that lasts one clock.

Count ticks come from one of four sources: three prescaled internal enable strobes (divide by 1, 4 and 16 of a base tick, each arriving as a single-cycle strobe) or an external input pin. The pin is synchronised and edge-detected inside the block. The compare value can be written directly into the active comparator. It can also be held in a buffer that is copied into the comparator only at the period wrap, so a duty change never splits a period. A run bit starts and stops counting. A control register gates the inversions and lets software force the output level.

Top module: `pwm8_timer`

## Requirements
- R1: After reset, pwm_o and irq_o are 0, the counter is 0, the run bit is off, inversion is disabled and buffering is off.
- R2: Register 0 (mode) holds the tick source in bits [1:0], the period code in bits [3:2] and the buffer enable in bit 4. Period code 01 gives 64 ticks, 10 gives 128 ticks, and 11 or 00 gives 256 ticks. The counter climbs by one per tick up to period-1 and clears to 0 on the next tick.
- R3: With inversion enabled, pwm_o inverts at the clock edge on which a tick brings the counter to the active compare value. The compare value must be nonzero and below the period.
- R4: On each wrap, pwm_o inverts (if enabled) at the same edge. irq_o is then high for exactly one clock, in the cycle after that edge.
- R5: With buffering off, a write to register 2 (compare) replaces the active compare value at once, including in the middle of a period.
- R6: With buffering on, a compare write lands only in the buffer, and the buffer is copied to the active compare value at the next wrap. If a write and a wrap fall in the same cycle, the active value takes the buffer's previous content. The new value then waits for the following wrap.
- R7: Register 1 bit 0 is the run bit. While it is 0, the counter is held at 0, no ticks are counted, and pwm_o keeps its level except for software force commands.
- R8: Tick source codes are 00 external pin, 01 divide-by-1, 10 divide-by-4 and 11 divide-by-16. Strobes on the sources that are not selected have no effect on the count.
- R9: The external pin passes through a two-flop synchroniser and a rising-edge detector. A rise first sampled at clock edge k is counted at edge k+2. A pin held high for several cycles counts once.
- R10: Register 3 bit 0 enables inversion. While it is 0, neither a match nor a wrap changes pwm_o, and irq_o still pulses on every wrap.
- R11: A write to register 3 with bit 1 set forces pwm_o to 1, and with bit 2 set (bit 1 clear) forces it to 0. A forced level has priority over an inversion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 mode, 1 run, 2 compare, 3 output control |
| wr_data_i | input | 8 | Write data |
| tick_div1_i | input | 1 | Internal tick strobe, divide by 1 |
| tick_div4_i | input | 1 | Internal tick strobe, divide by 4 |
| tick_div16_i | input | 1 | Internal tick strobe, divide by 16 |
| ext_pin_i | input | 1 | External count input, asynchronous |
| pwm_o | output | 1 | PWM output flip-flop |
| irq_o | output | 1 | One-clock pulse per period wrap |

## Verification
In buffered mode, a software compare write and the period wrap can land on the same clock edge. There the buffer copy and the buffer update contend. The bench times a compare write to hit the wrap edge exactly, right after an earlier buffered write has been placed. It then judges by the edges at which pwm_o inverts in the following two periods: the next period must use the earlier value and the one after must use the colliding value.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  typedef enum logic [1:0] {
    SRC_PIN   = 2'd0,
    SRC_DIV1  = 2'd1,
    SRC_DIV4  = 2'd2,
    SRC_DIV16 = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_RUN  = 2'd1,
    REG_CMP  = 2'd2,
    REG_FFC  = 2'd3
  } reg_e;

  typedef struct packed {
    logic       buf_en;
    logic [1:0] per;
    src_e       src;
  } mode_t;

  localparam int unsigned MODE_W  = $bits(mode_t);
  localparam int unsigned FFC_EN  = 0;
  localparam int unsigned FFC_SET = 1;
  localparam int unsigned FFC_CLR = 2;
endpackage

// File: rtl/pwm8_tick_sel.sv
module pwm8_tick_sel
  import pwm8_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic tick_div1_i,
  input  logic tick_div4_i,
  input  logic tick_div16_i,
  input  logic ext_pin_i,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_last_q;
  logic                   pin_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '0;
      pin_last_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_pin_i};
      pin_last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_tick = sync_q[SYNC_STAGES-1] & ~pin_last_q;

  always_comb begin
    unique case (src_i)
      SRC_PIN:   tick_o = pin_tick;
      SRC_DIV1:  tick_o = tick_div1_i;
      SRC_DIV4:  tick_o = tick_div4_i;
      default:   tick_o = tick_div16_i;
    endcase
  end
endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned MIN_EXP = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [1:0]       per_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] top_o,
  output logic             ovf_o,
  output logic             match_o
);
  localparam logic [CNT_W:0] TOP_SHORT = (CNT_W+1)'((1 << MIN_EXP) - 1);
  localparam logic [CNT_W:0] TOP_MID   = (CNT_W+1)'((1 << (MIN_EXP + 1)) - 1);
  localparam logic [CNT_W:0] TOP_FULL  = (CNT_W+1)'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   top_w;
  logic [CNT_W:0]   nxt;
  logic             step;

  always_comb begin
    unique case (per_i)
      2'd1:    top_w = TOP_SHORT;
      2'd2:    top_w = TOP_MID;
      default: top_w = TOP_FULL;
    endcase
  end

  assign top_o   = top_w[CNT_W-1:0];
  assign nxt     = {1'b0, cnt_q} + 1'b1;
  assign step    = run_i & tick_i;
  // >= so a period shortened mid-run still wraps at once
  assign ovf_o   = step & (cnt_q >= top_o);
  // match on the count being entered, so the edge aligns with the counter
  assign match_o = step & ~ovf_o & (nxt == {1'b0, cmp_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (ovf_o)   cnt_q <= '0;
    else if (step)    cnt_q <= nxt[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned MIN_EXP     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tick_div1_i,
  input  logic             tick_div4_i,
  input  logic             tick_div16_i,
  input  logic             ext_pin_i,
  output logic             pwm_o,
  output logic             irq_o
);
  reg_e             addr;
  mode_t            mode_q;
  logic             run_q;
  logic [CNT_W-1:0] cmp_buf_q;
  logic [CNT_W-1:0] cmp_act_q;
  logic             tog_en_q;
  logic             pwm_q;
  logic             irq_q;
  logic             wr_mode, wr_run, wr_cmp, ffc_wr;
  logic             tick, ovf, match;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_cnt;
  logic             unused_bits;

  assign addr    = reg_e'(wr_addr_i);
  assign wr_mode = wr_en_i && (addr == REG_MODE);
  assign wr_run  = wr_en_i && (addr == REG_RUN);
  assign wr_cmp  = wr_en_i && (addr == REG_CMP);
  assign ffc_wr  = wr_en_i && (addr == REG_FFC);
  assign unused_bits = ^wr_data_i[CNT_W-1:MODE_W];

  pwm8_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (mode_q.src),
    .tick_div1_i (tick_div1_i),
    .tick_div4_i (tick_div4_i),
    .tick_div16_i(tick_div16_i),
    .ext_pin_i   (ext_pin_i),
    .tick_o      (tick)
  );

  pwm8_counter #(.CNT_W(CNT_W), .MIN_EXP(MIN_EXP)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .tick_i (tick),
    .per_i  (mode_q.per),
    .cmp_i  (cmp_act_q),
    .cnt_o  (cnt_q),
    .top_o  (top_cnt),
    .ovf_o  (ovf),
    .match_o(match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      run_q     <= 1'b0;
      tog_en_q  <= 1'b0;
      cmp_buf_q <= '0;
      cmp_act_q <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_t'(wr_data_i[MODE_W-1:0]);
      if (wr_run)  run_q  <= wr_data_i[0];
      if (ffc_wr)  tog_en_q <= wr_data_i[FFC_EN];
      if (wr_cmp)  cmp_buf_q <= wr_data_i;
      // shift uses the buffer content from before any same-cycle write
      if (ovf && mode_q.buf_en)         cmp_act_q <= cmp_buf_q;
      else if (wr_cmp && !mode_q.buf_en) cmp_act_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= ovf;
      if (ffc_wr && wr_data_i[FFC_SET])      pwm_q <= 1'b1;
      else if (ffc_wr && wr_data_i[FFC_CLR]) pwm_q <= 1'b0;
      else if (tog_en_q && (match || ovf))   pwm_q <= ~pwm_q;
    end
  end

  assign pwm_o = pwm_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/pwm8_timer_chk.sv
module pwm8_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] top_i,
  input logic             run_i,
  input logic             tick_i,
  input logic             ovf_i,
  input logic             tog_en_i,
  input logic             ffc_wr_i,
  input logic             pwm_i,
  input logic             irq_i
);
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_i >= top_i) |=> (cnt_i == '0));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_i < top_i) |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_i));

  p_irq_after_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> irq_i);

  p_irq_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  p_stop_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_i == '0));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ffc_wr_i) |=> $stable(pwm_i));

  p_no_toggle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tog_en_i && !ffc_wr_i) |=> $stable(pwm_i));
endmodule

bind pwm8_timer pwm8_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_i   (cnt_q),
  .top_i   (top_cnt),
  .run_i   (run_q),
  .tick_i  (tick),
  .ovf_i   (ovf),
  .tog_en_i(tog_en_q),
  .ffc_wr_i(ffc_wr),
  .pwm_i   (pwm_o),
  .irq_i   (irq_o)
);

// File: tb/pwm8_timer_tb.sv
module pwm8_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick1 = 1'b1;
  logic       tick4 = 1'b0;
  logic       tick16 = 1'b0;
  logic       pin = 1'b0;
  logic       pwm, irq;

  always #4 clk = ~clk;

  pwm8_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_div1_i(tick1), .tick_div4_i(tick4),
    .tick_div16_i(tick16), .ext_pin_i(pin), .pwm_o(pwm), .irq_o(irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct { int c; logic v; string r; } ev_t;
  ev_t  pq[$];
  ev_t  iq[$];
  ev_t  m_e;
  logic exp_lvl = 1'b0;
  logic pwm_prev = 1'b0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic push_tog(input int c, input string r);
    exp_lvl = ~exp_lvl;
    pq.push_back('{c, exp_lvl, r});
  endtask

  task automatic push_irq(input int c, input string r);
    iq.push_back('{c, 1'b1, r});
  endtask

  // monitor: compare observed output events against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (pwm !== pwm_prev) begin
        if (pq.size() == 0) chk(0, "R3 unexpected pwm edge", cyc, -1);
        else begin
          m_e = pq.pop_front();
          chk(m_e.c == cyc && m_e.v === pwm, m_e.r, cyc, m_e.c);
        end
        pwm_prev = pwm;
      end
      if (irq === 1'b1) begin
        if (iq.size() == 0) chk(0, "R4 unexpected irq", cyc, -1);
        else begin
          m_e = iq.pop_front();
          chk(m_e.c == cyc, m_e.r, cyc, m_e.c);
        end
      end
    end
  end

  // write lands at edge (cyc at call + 2) when called at a negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int e);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; e = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_ff(input logic [7:0] d, input string r);
    logic lvl;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = d;
    lvl = d[1] ? 1'b1 : (d[2] ? 1'b0 : exp_lvl);
    if (lvl != exp_lvl) push_tog(cyc + 1, r);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic pulse4(input bit last);
    @(negedge clk);
    tick4 = 1'b1;
    if (last) push_tog(cyc + 1, "R8 div4 match");
    @(negedge clk);
    tick4 = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_pin(input bit last);
    @(negedge clk);
    pin = 1'b1;
    if (last) push_tog(cyc + 3, "R9 pin match");
    repeat (3) @(negedge clk);
    pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc == 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int e, d;
    repeat (3) @(negedge clk);
    chk(pwm === 1'b0, "R1 pwm reset", pwm, 0);
    chk(irq === 1'b0, "R1 irq reset", irq, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pwm === 1'b0, "R1 pwm after release", pwm, 0);

    // A: period 64, compare 20, unbuffered, div1
    wr(2'd3, 8'h01, d);
    wr(2'd0, 8'h05, d);
    wr(2'd2, 8'd20, d);
    wr(2'd1, 8'h01, e);
    push_tog(e + 20, "R3 match A1");
    push_tog(e + 64, "R4 wrap A1");   push_irq(e + 64, "R4 irq A1");
    push_tog(e + 84, "R3 match A2");
    push_tog(e + 128, "R2 wrap 64");  push_irq(e + 128, "R2 irq 64");
    wait_until(e + 140);
    wr(2'd1, 8'h00, d);
    repeat (30) @(negedge clk);
    chk(pwm === exp_lvl, "R7 hold after stop", pwm, exp_lvl);
    wr_ff(8'h03, "R11 force set");
    wr_ff(8'h05, "R11 force clear");
    wr_ff(8'h07, "R11 set wins");
    wr_ff(8'h05, "R11 clear");
    repeat (3) @(negedge clk);
    chk(pwm === 1'b0, "R11 level after clear", pwm, 0);

    // B: period 256, unbuffered mid-period write
    wr(2'd0, 8'h0D, d);
    wr(2'd2, 8'd200, d);
    wr(2'd1, 8'h01, e);
    push_tog(e + 50, "R5 immediate compare");
    push_tog(e + 256, "R2 wrap 256"); push_irq(e + 256, "R2 irq 256");
    wait_until(e + 10);
    wr(2'd2, 8'd50, d);
    wait_until(e + 260);
    wr(2'd1, 8'h00, d);

    // C: period 128, buffered mid-period write
    wr(2'd0, 8'h09, d);
    wr(2'd2, 8'd100, d);
    wr(2'd0, 8'h19, d);
    wr(2'd1, 8'h01, e);
    push_tog(e + 100, "R6 old compare kept");
    push_tog(e + 128, "R2 wrap 128"); push_irq(e + 128, "R2 irq 128");
    push_tog(e + 158, "R6 buffered compare");
    push_tog(e + 256, "R4 wrap C2");  push_irq(e + 256, "R4 irq C2");
    wait_until(e + 50);
    wr(2'd2, 8'd30, d);
    wait_until(e + 260);
    wr(2'd1, 8'h00, d);

    // D: buffered write colliding with the wrap edge
    wr(2'd0, 8'h05, d);
    wr(2'd2, 8'd10, d);
    wr(2'd0, 8'h15, d);
    wr(2'd1, 8'h01, e);
    push_tog(e + 10, "R6 D1 match");
    push_tog(e + 64, "R4 D1 wrap");    push_irq(e + 64, "R4 D1 irq");
    push_tog(e + 104, "R6 D2 uses earlier buffer");
    push_tog(e + 128, "R4 D2 wrap");   push_irq(e + 128, "R4 D2 irq");
    push_tog(e + 178, "R6 D3 uses colliding write");
    push_tog(e + 192, "R4 D3 wrap");   push_irq(e + 192, "R4 D3 irq");
    wait_until(e + 20);
    wr(2'd2, 8'd40, d);
    wait_until(e + 62);
    wr(2'd2, 8'd50, d);
    chk(d == e + 64, "R6 collision timing", d, e + 64);
    wait_until(e + 195);
    wr(2'd1, 8'h00, d);

    // E: inversion disabled, irq still pulses
    wr(2'd3, 8'h00, d);
    wr(2'd0, 8'h05, d);
    wr(2'd2, 8'd20, d);
    wr(2'd1, 8'h01, e);
    push_irq(e + 64, "R10 irq without toggle");
    wait_until(e + 70);
    chk(pwm === exp_lvl, "R10 pwm unchanged", pwm, exp_lvl);
    wr(2'd1, 8'h00, d);
    wr(2'd3, 8'h01, d);

    // F: divide-by-4 source, div1 strobes must be ignored
    wr(2'd0, 8'h06, d);
    wr(2'd2, 8'd5, d);
    wr(2'd1, 8'h01, e);
    repeat (10) @(negedge clk);
    chk(pwm === exp_lvl, "R8 unselected source ignored", pwm, exp_lvl);
    for (int i = 0; i < 5; i++) pulse4(i == 4);
    repeat (4) @(negedge clk);
    chk(pwm === 1'b1, "R8 level after div4 match", pwm, 1);
    wr(2'd1, 8'h00, d);

    // G: external pin source, long high pulses count once
    wr(2'd0, 8'h04, d);
    wr(2'd2, 8'd3, d);
    wr(2'd1, 8'h01, e);
    pulse_pin(1'b0);
    pulse_pin(1'b0);
    chk(pwm === exp_lvl, "R9 no match after two edges", pwm, exp_lvl);
    pulse_pin(1'b1);
    repeat (4) @(negedge clk);
    chk(pwm === 1'b0, "R9 level after pin match", pwm, 0);
    wr(2'd1, 8'h00, d);

    repeat (20) @(negedge clk);
    chk(pq.size() == 0, "R3 pending pwm events", pq.size(), 0);
    chk(iq.size() == 0, "R4 pending irq events", iq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule